// File: doc/BRIEF.md
# SDRAM Refresh Interval Scheduler

This block watches the four command strobes that a memory controller drives to an SDRAM device and finds every auto-refresh command on them. From the most recent refresh it times two things. The first is the deadline for the next refresh. The second is a short recovery window after each refresh, during which the controller must not issue other commands. Issuing commands and arbitrating against user traffic belong to the controller; this block only tells it when to act.

The block gives three registered indications:

- an "early" hint, meaning fewer than a quarter of the interval counter's range remains, so an idle controller can refresh ahead of time;
- an "urgent" flag, meaning the interval has run out and a refresh must be forced now;
- a "busy" flag, meaning the device is still recovering from a refresh.

The interval length is worked out during elaboration from the clock frequency, the number of rows and the retention period.

Top module: `sdram_refresh_sched`

## Requirements
- R1: A command counts as an auto-refresh only when chip select, RAS and CAS are all low and WE is high, that is {cs_n,ras_n,cas_n,we_n} = 4'b0001. The other fifteen combinations change none of the outputs.
- R2: The reload count is PERIOD_MS*1000*CLK_MHZ/ROWS, truncated. This gives 625 at 80 MHz and 390 at 50 MHz, with 64 ms and 8192 rows.
- R3: With no further refresh, `refresh_urgent` first reads high RELOAD+1 clock edges after the edge that sampled a refresh. It then stays high until the next refresh.
- R4: `refresh_urgent` reads low in the cycle after an edge that samples a refresh, even when it was high before.
- R5: `refresh_busy` reads high during the 7 cycles after a refresh edge (edges T through T+6) and low from edge T+7 onward.
- R6: A refresh sampled while `refresh_busy` is high restarts the 7-cycle busy window from that refresh.
- R7: `refresh_early` reads high once the remaining count drops below 2^(CNT_W-EARLY_BITS) (256 by default). That is from edge T+RELOAD-255 onward, and it holds until the next refresh.
- R8: After a synchronous reset, with no refresh issued yet, `refresh_urgent` and `refresh_early` are high and `refresh_busy` is low.
- R9: A refresh sampled before the interval has expired reloads the full interval, so the R3 deadline is measured from the latest refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | input | 1 | Chip select strobe seen on the memory bus, active low |
| cmd_ras_n | input | 1 | Row strobe seen on the memory bus, active low |
| cmd_cas_n | input | 1 | Column strobe seen on the memory bus, active low |
| cmd_we_n | input | 1 | Write-enable strobe seen on the memory bus, active low |
| refresh_urgent | output | 1 | Interval expired; a refresh must be issued now |
| refresh_early | output | 1 | Deadline is near; refresh if the bus is idle |
| refresh_busy | output | 1 | Recovery window after a refresh is still open |

## Verification
The bench first walks all fifteen non-refresh strobe codes. This separates a full four-signal decode from one that looks only at a subset of the strobes. Single refreshes followed by long idle stretches pin the exact edge on which the urgent flag rises and the early hint turns on. Pairs of refreshes spaced closer than the interval or the busy window show that both timers restart instead of running on. Random phases with sparse, medium and dense refresh rates, mixed with random non-refresh codes, compare all three flags every cycle against a model based on cycles elapsed since the last refresh.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  // Cycles between refreshes so that every row is refreshed within the retention period
  function automatic int unsigned reload_count(input int unsigned period_ms,
                                               input int unsigned clk_mhz,
                                               input int unsigned rows);
    return (period_ms * 1000 * clk_mhz) / rows;
  endfunction

endpackage

// File: rtl/refresh_cmd_decode.sv
module refresh_cmd_decode
  import sdram_refresh_pkg::*;
(
  input  sdram_cmd_t cmd,
  output logic       is_refresh
);
  assign is_refresh = !cmd.cs_n && !cmd.ras_n && !cmd.cas_n && cmd.we_n;
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W      = 10,
  parameter int RELOAD     = 625,
  parameter int EARLY_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic urgent,
  output logic early
);
  localparam int MAX_CNT = (1 << CNT_W) - 1;
  localparam int LOAD_I  = (RELOAD > MAX_CNT) ? MAX_CNT : RELOAD;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD_I);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      urgent <= 1'b1;
    end else begin
      if (hit)
        remain <= LOAD_V;
      else if (remain != '0)
        remain <= remain - ONE;
      urgent <= (remain == '0) && !hit;
    end
  end

  assign early = (remain[CNT_W-1 -: EARLY_BITS] == '0);
endmodule

// File: rtl/refresh_busy_timer.sv
module refresh_busy_timer #(
  parameter int BUSY_W      = 3,
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic busy
);
  localparam logic [BUSY_W-1:0] LOAD_V = BUSY_W'(BUSY_CYCLES);
  localparam logic [BUSY_W-1:0] ONE    = BUSY_W'(1);

  logic [BUSY_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      busy <= 1'b0;
    end else begin
      if (hit)
        left <= LOAD_V;
      else if (left != '0)
        left <= left - ONE;
      busy <= (left != '0) || hit;
    end
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int CLK_MHZ     = 80,
  parameter int PERIOD_MS   = 64,
  parameter int ROWS        = 8192,
  parameter int CNT_W       = 10,
  parameter int EARLY_BITS  = 2,
  parameter int BUSY_W      = 3,
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_cs_n,
  input  logic cmd_ras_n,
  input  logic cmd_cas_n,
  input  logic cmd_we_n,
  output logic refresh_urgent,
  output logic refresh_early,
  output logic refresh_busy
);
  localparam int RELOAD = int'(reload_count(PERIOD_MS, CLK_MHZ, ROWS));

  sdram_cmd_t bus_cmd;
  logic       ref_hit;

  assign bus_cmd = '{cs_n: cmd_cs_n, ras_n: cmd_ras_n, cas_n: cmd_cas_n, we_n: cmd_we_n};

  refresh_cmd_decode u_decode (
    .cmd        (bus_cmd),
    .is_refresh (ref_hit)
  );

  refresh_interval_timer #(
    .CNT_W      (CNT_W),
    .RELOAD     (RELOAD),
    .EARLY_BITS (EARLY_BITS)
  ) u_interval (
    .clk    (clk),
    .rst    (rst),
    .hit    (ref_hit),
    .urgent (refresh_urgent),
    .early  (refresh_early)
  );

  refresh_busy_timer #(
    .BUSY_W      (BUSY_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk  (clk),
    .rst  (rst),
    .hit  (ref_hit),
    .busy (refresh_busy)
  );
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int RELOAD      = 625,
  parameter int BUSY_CYCLES = 6
) (
  input logic clk,
  input logic rst,
  input logic hit,
  input logic urgent,
  input logic early,
  input logic busy
);
  localparam int SINCE_W = $clog2(RELOAD + 2) + 2;
  localparam logic [SINCE_W-1:0] DUE_V  = SINCE_W'(RELOAD + 1);
  localparam logic [SINCE_W-1:0] BUSY_V = SINCE_W'(BUSY_CYCLES);
  localparam logic [SINCE_W-1:0] ONE    = SINCE_W'(1);

  logic [SINCE_W-1:0] since;
  logic               seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (hit) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since != '1) begin
      since <= since + ONE;
    end
  end

  // R4: a sampled refresh clears the urgent flag and opens the busy window
  assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (!urgent && busy));

  // R3: deadline not reported before RELOAD+1 edges
  assert_not_early_urgent_R3: assert property (@(posedge clk) disable iff (rst)
    (seen && since < DUE_V) |-> !urgent);

  // R3: deadline reported from RELOAD+1 edges on
  assert_urgent_on_time_R3: assert property (@(posedge clk) disable iff (rst)
    (seen && since >= DUE_V) |-> urgent);

  // R5: busy window length
  assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
    seen |-> (busy == (since <= BUSY_V)));

  // R7: urgent never without early hint
  assert_urgent_implies_early_R7: assert property (@(posedge clk) disable iff (rst)
    urgent |-> early);

  // R7: early hint holds until a refresh
  assert_early_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (early && !hit) |=> early);

  // R8: before any refresh the deadline is already due
  assert_initial_due_R8: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (urgent && early && !busy));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .RELOAD      (RELOAD),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .hit    (ref_hit),
  .urgent (refresh_urgent),
  .early  (refresh_early),
  .busy   (refresh_busy)
);

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
  localparam int CLK_MHZ = 50;
  localparam int EXP_RELOAD = (64 * 1000 * 50) / 8192;  // R2: 390
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic refresh_urgent, refresh_early, refresh_busy;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit seen   = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(.CLK_MHZ(CLK_MHZ)) uut (
    .clk            (clk),
    .rst            (rst),
    .cmd_cs_n       (cs_n),
    .cmd_ras_n      (ras_n),
    .cmd_cas_n      (cas_n),
    .cmd_we_n       (we_n),
    .refresh_urgent (refresh_urgent),
    .refresh_early  (refresh_early),
    .refresh_busy   (refresh_busy)
  );

  function automatic logic exp_urgent();
    return !seen || (k >= EXP_RELOAD + 1);
  endfunction
  function automatic logic exp_early();
    return !seen || (k >= EXP_RELOAD - 255);
  endfunction
  function automatic logic exp_busy();
    return seen && (k <= 6);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (k=%0d)", req, what, act, exp, k);
    end
  endtask

  task automatic check_all(input string tag);
    check({"R3 ", tag}, "urgent", refresh_urgent, exp_urgent());
    check({"R7 ", tag}, "early",  refresh_early,  exp_early());
    check({"R5 ", tag}, "busy",   refresh_busy,   exp_busy());
  endtask

  // drive one command, let one edge pass, update the model, sample on the falling edge
  task automatic cycle(input logic [3:0] cmd, input string tag);
    {cs_n, ras_n, cas_n, we_n} = cmd;
    @(posedge clk);
    if (cmd == REF) begin
      k = 0;
      seen = 1'b1;
    end else if (k < 1000000) begin
      k++;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic measure_rise(input string req);
    int n = 0;
    do begin
      cycle(NOP, req);
      n++;
    end while (!refresh_urgent && n < 1000);
    checks++;
    if (n != EXP_RELOAD + 1) begin
      fails++;
      $display("FAIL %s rise edge: actual %0d expected %0d", req, n, EXP_RELOAD + 1);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: state after reset
    check("R8", "urgent", refresh_urgent, 1'b1);
    check("R8", "early",  refresh_early,  1'b1);
    check("R8", "busy",   refresh_busy,   1'b0);
    repeat (20) cycle(NOP, "R8 idle");

    // R1: every non-refresh code leaves the outputs alone
    for (int c = 0; c < 16; c++) begin
      if (4'(c) != REF) cycle(4'(c), "R1 near-miss");
    end
    check("R1", "urgent after near-miss", refresh_urgent, 1'b1);
    check("R1", "busy after near-miss",   refresh_busy,   1'b0);

    // R4 then R2/R3: exact rise edge
    cycle(REF, "R4");
    check("R4", "urgent after refresh", refresh_urgent, 1'b0);
    measure_rise("R2 R3");
    repeat (5) cycle(NOP, "R3 hold");

    // R4: refresh on an urgent cycle, then R9: early reload
    cycle(REF, "R4 while urgent");
    repeat (100) cycle(NOP, "R9 gap");
    cycle(REF, "R9 reload");
    measure_rise("R9");

    // R6: refresh inside busy window
    cycle(REF, "R6 first");
    repeat (3) cycle(NOP, "R6 gap");
    cycle(REF, "R6 second");
    repeat (6) cycle(NOP, "R6 window");
    check("R6", "busy at last window cycle", refresh_busy, 1'b1);
    cycle(NOP, "R6 close");
    check("R6", "busy after window", refresh_busy, 1'b0);

    // random phases: sparse, medium, dense refresh spacing
    for (int ph = 0; ph < 3; ph++) begin
      int unsigned rate = (ph == 0) ? 600 : (ph == 1) ? 50 : 5;
      for (int i = 0; i < 4000; i++) begin
        logic [3:0] c;
        if ($urandom % rate == 0) c = REF;
        else begin
          c = 4'($urandom);
          if (c == REF) c = 4'b1001;
        end
        cycle(c, "R1 R9 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule